// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This combinational unit decides, for a single 8-bit opcode, whether that opcode is a conditional branch and, if so, whether the branch is taken. It looks only at the opcode, six condition-code bits (carry, zero, negative, overflow, half-carry, interrupt mask) and the level of an external interrupt pin. Computing the target address and updating the program counter belong to the surrounding core.

Branch opcodes come in two groups, picked by the upper nibble. In both groups, opcode bits 3:1 select a condition and bit 0 inverts it, so each selector value names a condition and its complement. The flag group (upper nibble 0x2) tests single flags, one unsigned magnitude relation, or the pin. The signed group (upper nibble 0x9) holds only two selectors, greater-or-equal and greater-than. The other selector values in that nibble are not branches.

Top module: `bce_branch_eval`

## Requirements
- R1: `is_branch` is 1 exactly for opcodes 0x20 to 0x2F and 0x90 to 0x93, and 0 for every other opcode.
- R2: When `is_branch` is 0, `take_branch` is 0 whatever the flag and pin inputs are.
- R3: For every branch opcode, flipping opcode bit 0 inverts `take_branch` under the same flags and pin.
- R4: Opcode 0x20 is always taken and opcode 0x21 is never taken.
- R5: Opcode 0x22 (unsigned higher) is taken when carry and zero are both 0, and opcode 0x23 (lower-or-same) is taken when carry OR zero is 1.
- R6: Opcode 0x24 is taken when carry is 0, and opcode 0x25 when carry is 1.
- R7: Opcode 0x26 is taken when zero is 0, and opcode 0x27 when zero is 1.
- R8: Opcode 0x28 is taken when half-carry is 0, and opcode 0x29 when it is 1.
- R9: Opcode 0x2A is taken when negative is 0, and opcode 0x2B when it is 1.
- R10: Opcode 0x2C is taken when the interrupt mask is 0, and opcode 0x2D when it is 1.
- R11: Opcode 0x2E is taken when `irq_level` is 0, and opcode 0x2F when it is 1.
- R12: Opcode 0x90 (signed greater-or-equal) is taken when negative XOR overflow is 0, and opcode 0x91 when it is 1.
- R13: Opcode 0x92 (signed greater-than) is taken when zero is 0 and negative XOR overflow is 0, and opcode 0x93 is taken otherwise.
- R14: Opcodes 0x94 to 0x9F give `is_branch` 0 and `take_branch` 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opcode | input | 8 | Opcode under evaluation |
| cc_carry | input | 1 | Carry flag |
| cc_zero | input | 1 | Zero flag |
| cc_neg | input | 1 | Negative flag |
| cc_ovf | input | 1 | Two's-complement overflow flag |
| cc_half | input | 1 | Half-carry flag |
| cc_imask | input | 1 | Interrupt mask flag |
| irq_level | input | 1 | Current level of the external interrupt pin |
| is_branch | output | 1 | Opcode is a conditional branch |
| take_branch | output | 1 | Branch is taken (0 when not a branch) |

## Verification
The assertions check, on every evaluation, that a non-branch never reports taken, that the unconditional selector and the pin selector match their ports, that the nibble 0x9 selectors past the second are rejected, and that signed greater-than implies greater-or-equal. The complement pairing of R3 and the exact truth table of each flag condition need two opcodes or a full flag sweep to show. Only the bench can demonstrate these. It drives all 256 opcodes against all 128 combinations of flags and pin, and compares each result with a table it computes itself.

// File: rtl/bce_pkg.sv
package bce_pkg;

  localparam int OPC_W    = 8;
  localparam int IDX_W    = 3;
  localparam int NUM_COND = 1 << IDX_W;
  localparam int HI_W     = 4;

  typedef enum logic [1:0] {
    GRP_NONE   = 2'd0,
    GRP_FLAG   = 2'd1,
    GRP_SIGNED = 2'd2
  } grp_e;

  typedef struct packed {
    grp_e             grp;
    logic [IDX_W-1:0] idx;
    logic             inv;
  } dec_t;

  // Base condition (inversion bit clear) for the flag-based group.
  function automatic logic flag_cond(input logic [IDX_W-1:0] idx,
                                     input logic c, input logic z,
                                     input logic n, input logic h,
                                     input logic i, input logic pin);
    logic r;
    case (idx)
      3'd0:    r = 1'b1;
      3'd1:    r = ~(c | z);
      3'd2:    r = ~c;
      3'd3:    r = ~z;
      3'd4:    r = ~h;
      3'd5:    r = ~n;
      3'd6:    r = ~i;
      default: r = ~pin;
    endcase
    return r;
  endfunction

  // Base condition for the signed-comparison group.
  function automatic logic signed_cond(input logic [IDX_W-1:0] idx,
                                       input logic z, input logic n,
                                       input logic v);
    logic ge;
    logic r;
    ge = ~(n ^ v);
    case (idx)
      3'd0:    r = ge;
      3'd1:    r = ge & ~z;
      default: r = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/bce_decode.sv
module bce_decode
  import bce_pkg::*;
#(
  parameter logic [HI_W-1:0] HI_FLAG    = 4'h2,
  parameter logic [HI_W-1:0] HI_SIGNED  = 4'h9,
  parameter int              SIGNED_CNT = 2
) (
  input  logic [OPC_W-1:0] opcode,
  output dec_t             dec
);

  localparam logic [IDX_W:0] SCNT = (IDX_W+1)'(SIGNED_CNT);

  logic [HI_W-1:0]  hi_nib;
  logic [IDX_W-1:0] sel;
  logic             hit_flag;
  logic             hit_signed;

  assign hi_nib     = opcode[OPC_W-1:OPC_W-HI_W];
  assign sel        = opcode[IDX_W:1];
  assign hit_flag   = (hi_nib == HI_FLAG);
  assign hit_signed = (hi_nib == HI_SIGNED) && ({1'b0, sel} < SCNT);

  always_comb begin
    dec.idx = sel;
    dec.inv = opcode[0];
    if (hit_flag)        dec.grp = GRP_FLAG;
    else if (hit_signed) dec.grp = GRP_SIGNED;
    else                 dec.grp = GRP_NONE;
  end

endmodule

// File: rtl/bce_flag_conds.sv
module bce_flag_conds
  import bce_pkg::*;
(
  input  logic [IDX_W-1:0] idx,
  input  logic             c,
  input  logic             z,
  input  logic             n,
  input  logic             h,
  input  logic             i,
  input  logic             pin,
  output logic             cond
);

  logic [NUM_COND-1:0] cond_vec;

  for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
    assign cond_vec[k] = flag_cond(IDX_W'(k), c, z, n, h, i, pin);
  end

  assign cond = cond_vec[idx];

  always_comb begin
    // R4
    uncond_entry_chk: assert (cond_vec[0] == 1'b1);
    // R5
    higher_excl_chk: assert (!(cond_vec[1] && (c || z)));
  end

endmodule

// File: rtl/bce_signed_conds.sv
module bce_signed_conds
  import bce_pkg::*;
#(
  parameter int SIGNED_CNT = 2
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             z,
  input  logic             n,
  input  logic             v,
  output logic             cond
);

  logic [NUM_COND-1:0] cond_vec;

  for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
    if (k < SIGNED_CNT) begin : g_live
      assign cond_vec[k] = signed_cond(IDX_W'(k), z, n, v);
    end else begin : g_dead
      assign cond_vec[k] = 1'b0;
    end
  end

  assign cond = cond_vec[idx];

  always_comb begin
    // R13
    gt_implies_ge_chk: assert (!cond_vec[1] || cond_vec[0]);
  end

endmodule

// File: rtl/bce_branch_eval.sv
module bce_branch_eval
  import bce_pkg::*;
#(
  parameter logic [HI_W-1:0] HI_FLAG    = 4'h2,
  parameter logic [HI_W-1:0] HI_SIGNED  = 4'h9,
  parameter int              SIGNED_CNT = 2
) (
  input  logic [OPC_W-1:0] opcode,
  input  logic             cc_carry,
  input  logic             cc_zero,
  input  logic             cc_neg,
  input  logic             cc_ovf,
  input  logic             cc_half,
  input  logic             cc_imask,
  input  logic             irq_level,
  output logic             is_branch,
  output logic             take_branch
);

  dec_t dec;
  logic flag_hit;
  logic signed_hit;
  logic base_cond;

  bce_decode #(
    .HI_FLAG   (HI_FLAG),
    .HI_SIGNED (HI_SIGNED),
    .SIGNED_CNT(SIGNED_CNT)
  ) u_dec (
    .opcode(opcode),
    .dec   (dec)
  );

  bce_flag_conds u_flag (
    .idx (dec.idx),
    .c   (cc_carry),
    .z   (cc_zero),
    .n   (cc_neg),
    .h   (cc_half),
    .i   (cc_imask),
    .pin (irq_level),
    .cond(flag_hit)
  );

  bce_signed_conds #(
    .SIGNED_CNT(SIGNED_CNT)
  ) u_sgn (
    .idx (dec.idx),
    .z   (cc_zero),
    .n   (cc_neg),
    .v   (cc_ovf),
    .cond(signed_hit)
  );

  always_comb begin
    case (dec.grp)
      GRP_FLAG:   base_cond = flag_hit;
      GRP_SIGNED: base_cond = signed_hit;
      default:    base_cond = 1'b0;
    endcase
  end

  assign is_branch   = (dec.grp != GRP_NONE);
  assign take_branch = is_branch & (base_cond ^ dec.inv);

  always_comb begin
    // R2
    gate_chk: assert (is_branch || !take_branch);
    // R4
    always_taken_chk: assert (opcode != {HI_FLAG, 4'h0} || take_branch);
    // R11
    pin_low_chk: assert (opcode != {HI_FLAG, 4'hE} || (take_branch == !irq_level));
    // R14
    signed_tail_chk: assert (!(opcode[7:4] == HI_SIGNED && opcode[3:1] >= 3'd2) || !is_branch);
  end

endmodule

// File: tb/sim_bce_branch_eval.sv
module sim_bce_branch_eval;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opcode = 8'h00;
  logic       c = 0, z = 0, n = 0, v = 0, h = 0, i = 0, pin = 0;
  logic       is_branch, take_branch;
  int         checks = 0;
  int         errors = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  bce_branch_eval u0 (
    .opcode(opcode), .cc_carry(c), .cc_zero(z), .cc_neg(n), .cc_ovf(v),
    .cc_half(h), .cc_imask(i), .irq_level(pin),
    .is_branch(is_branch), .take_branch(take_branch)
  );

  function automatic bit exp_valid(input logic [7:0] op);
    return (op >= 8'h20 && op <= 8'h2F) || (op >= 8'h90 && op <= 8'h93);
  endfunction

  // Truth table written per opcode pair, each taken value from the requirements.
  function automatic bit exp_take(input logic [7:0] op, input bit fc, input bit fz,
                                  input bit fn, input bit fv, input bit fh,
                                  input bit fi, input bit fp);
    bit t;
    case (op)
      8'h20: t = 1;             8'h21: t = 0;               // R4
      8'h22: t = !fc && !fz;    8'h23: t = fc || fz;        // R5
      8'h24: t = !fc;           8'h25: t = fc;              // R6
      8'h26: t = !fz;           8'h27: t = fz;              // R7
      8'h28: t = !fh;           8'h29: t = fh;              // R8
      8'h2A: t = !fn;           8'h2B: t = fn;              // R9
      8'h2C: t = !fi;           8'h2D: t = fi;              // R10
      8'h2E: t = !fp;           8'h2F: t = fp;              // R11
      8'h90: t = (fn == fv);    8'h91: t = (fn != fv);      // R12
      8'h92: t = !fz && (fn == fv);
      8'h93: t = fz || (fn != fv);                          // R13
      default: t = 0;                                       // R2
    endcase
    return t;
  endfunction

  function automatic string tag_of(input logic [7:0] op);
    case (op[7:1])
      7'h10: return "R4";  7'h11: return "R5";  7'h12: return "R6";
      7'h13: return "R7";  7'h14: return "R8";  7'h15: return "R9";
      7'h16: return "R10"; 7'h17: return "R11"; 7'h48: return "R12";
      7'h49: return "R13";
      default: return (op[7:4] == 4'h9) ? "R14" : "R2";
    endcase
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s op=%02h flags=%b%b%b%b%b%b pin=%b actual=%b expected=%b",
               req, what, opcode, c, z, n, v, h, i, pin, act, exp);
    end
  endtask

  initial begin
    bit prev_take;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", is_branch, 1'b0, "reset valid");
    check("R2", take_branch, 1'b0, "reset taken");
    rst = 1'b0;
    for (int op = 0; op < 256; op++) begin
      for (int f = 0; f < 128; f++) begin
        @(posedge clk);
        opcode = 8'(op);
        {c, z, n, v, h, i, pin} = 7'(f);
        @(negedge clk);
        check("R1", is_branch, exp_valid(opcode), "valid");
        check(tag_of(opcode), take_branch,
              exp_take(opcode, c, z, n, v, h, i, pin), "taken");
      end
    end
    // R3: complement pairs under a few flag patterns, compared opcode to opcode.
    for (int op = 0; op < 256; op += 2) begin
      if (exp_valid(8'(op))) begin
        for (int f = 0; f < 128; f += 37) begin
          @(posedge clk);
          opcode = 8'(op);
          {c, z, n, v, h, i, pin} = 7'(f);
          @(negedge clk);
          prev_take = take_branch;
          @(posedge clk);
          opcode = 8'(op + 1);
          @(negedge clk);
          check("R3", take_branch, !prev_take, "complement");
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule